// File: doc/BRIEF.md
# Interrupt Priority Masking Gate

This block sits between an interrupt controller and a processor core. The controller presents the single most urgent pending request, as a valid flag and a priority number. The gate then decides, in the same cycle, whether the core may take that request. Two pieces of state shape the decision. The first is a one-bit global block flag, set and cleared by single-cycle strobes. The second is a priority threshold register.

The threshold has two write paths. A direct load replaces the value outright, so software can put back a value it saved earlier. A tighten-only load changes the value only when the new value masks more levels than the current one. A non-maskable request passes every mask. Both registers are read back on output ports.

The global flag is a two-state machine. `GM_OPEN` lets maskable requests through and `GM_BLOCKED` stops them. The transition `GM_OPEN -> GM_BLOCKED` fires on the block strobe. The transition `GM_BLOCKED -> GM_OPEN` fires on the unblock strobe when the block strobe is low. In every other case the machine stays in its current state.

Top module: `irq_prio_gate`

## Requirements
- R1: After reset, `gmask_q` is 0 and `thr_q` is 0.
- R2: While `gmask_q` is 1, `take_irq` is 0 unless `nmi_req` is 1.
- R3: A cycle with `gmask_set`=1 makes `gmask_q` 1 at the next clock. A cycle with `gmask_clr`=1 and `gmask_set`=0 makes `gmask_q` 0 at the next clock. When both strobes are high, set wins.
- R4: `take_irq` is 1 whenever `nmi_req` is 1, whatever the values of `gmask_q`, `thr_q` and `req_valid`.
- R5: Priority 0 is the most urgent level and there are 8 levels (0..7). With `gmask_q`=0, a nonzero threshold N blocks every request whose priority is N or larger. A threshold of 0 blocks nothing.
- R6: A cycle with `thr_wr`=1 loads `thr_wdata` into `thr_q` at the next clock, with no condition. If `thr_wr_max` is also 1 in that cycle, the direct load takes precedence.
- R7: A cycle with `thr_wr_max`=1 and `thr_wr`=0 loads `thr_wdata` only if it is nonzero and either `thr_q` is 0 or `thr_wdata` < `thr_q`. Otherwise `thr_q` does not change.
- R8: `take_irq` is combinational. It equals `nmi_req | (req_valid & !gmask_q & (thr_q==0 | req_prio<thr_q))`. When `req_valid` and `nmi_req` are both 0, `take_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A maskable request is pending |
| req_prio | input | PRIO_W | Priority of the pending request (0 is the most urgent) |
| nmi_req | input | 1 | Non-maskable request |
| thr_wr | input | 1 | Direct threshold load strobe |
| thr_wr_max | input | 1 | Tighten-only threshold load strobe |
| thr_wdata | input | PRIO_W | Data for either threshold load |
| gmask_set | input | 1 | Global block strobe |
| gmask_clr | input | 1 | Global unblock strobe |
| take_irq | output | 1 | The core may take the request |
| gmask_q | output | 1 | Read-back of the global block flag |
| thr_q | output | PRIO_W | Read-back of the threshold |

## Verification
The gate decision is tried over the full grid of threshold and request priority with the global flag clear. This separates an off-by-one at the threshold boundary from the "0 means off" special case. The same requests are then repeated with the flag set, with and without `nmi_req`, which shows that the flag blocks maskable requests but never the non-maskable one. Tighten-only loads are given values that are smaller, equal, larger and zero, which tells an accepted load from a rejected one. Simultaneous direct and tighten-only loads, and simultaneous set and clear strobes, show which write takes precedence.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic {
        GM_OPEN    = 1'b0,
        GM_BLOCKED = 1'b1
    } gm_state_t;

endpackage

// File: rtl/irq_gmask_fsm.sv
module irq_gmask_fsm
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic blocked_o
);

    gm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GM_OPEN:    if (set_i)           state_d = GM_BLOCKED;
            GM_BLOCKED: if (clr_i && !set_i) state_d = GM_OPEN;
            default:                         state_d = GM_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GM_OPEN;
        else        state_q <= state_d;
    end

    always_comb blocked_o = (state_q == GM_BLOCKED);

    AST_SET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> blocked_o);                                   // R3
    AST_CLR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !blocked_o);                      // R3

endmodule

// File: rtl/irq_thresh_reg.sv
module irq_thresh_reg #(
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              wr_max_i,
    input  logic [PRIO_W-1:0] wdata_i,
    output logic [PRIO_W-1:0] thr_o
);

    localparam logic [PRIO_W-1:0] OFF = '0;

    logic [PRIO_W-1:0] thr_q, thr_d;
    logic              tighten_ok;

    always_comb begin
        tighten_ok = (wdata_i != OFF) && ((thr_q == OFF) || (wdata_i < thr_q));
        thr_d = thr_q;
        if (wr_i)                        thr_d = wdata_i;
        else if (wr_max_i && tighten_ok) thr_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= OFF;
        else        thr_q <= thr_d;
    end

    assign thr_o = thr_q;

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (thr_o == $past(wdata_i)));                    // R6
    AST_NEVER_LOOSENS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_max_i && !wr_i) |=> ((thr_o == $past(thr_o)) ||
            ((thr_o != OFF) && (($past(thr_o) == OFF) || (thr_o < $past(thr_o)))))); // R7

endmodule

// File: rtl/irq_take_logic.sv
module irq_take_logic #(
    parameter int PRIO_W = 3
) (
    input  logic              req_valid_i,
    input  logic [PRIO_W-1:0] req_prio_i,
    input  logic              nmi_i,
    input  logic              blocked_i,
    input  logic [PRIO_W-1:0] thr_i,
    output logic              take_o
);

    logic prio_pass;

    always_comb begin
        prio_pass = (thr_i == '0) || (req_prio_i < thr_i);
        take_o    = nmi_i || (req_valid_i && !blocked_i && prio_pass);
    end

endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
    parameter int NUM_LEVELS = 8,
    parameter int PRIO_W     = $clog2(NUM_LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              nmi_req,
    input  logic              thr_wr,
    input  logic              thr_wr_max,
    input  logic [PRIO_W-1:0] thr_wdata,
    input  logic              gmask_set,
    input  logic              gmask_clr,
    output logic              take_irq,
    output logic              gmask_q,
    output logic [PRIO_W-1:0] thr_q
);

    irq_gmask_fsm u_gmask (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (gmask_set),
        .clr_i     (gmask_clr),
        .blocked_o (gmask_q)
    );

    irq_thresh_reg #(.PRIO_W(PRIO_W)) u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (thr_wr),
        .wr_max_i (thr_wr_max),
        .wdata_i  (thr_wdata),
        .thr_o    (thr_q)
    );

    irq_take_logic #(.PRIO_W(PRIO_W)) u_take (
        .req_valid_i (req_valid),
        .req_prio_i  (req_prio),
        .nmi_i       (nmi_req),
        .blocked_i   (gmask_q),
        .thr_i       (thr_q),
        .take_o      (take_irq)
    );

    AST_NMI_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> take_irq);                                  // R4
    AST_GLOBAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask_q && !nmi_req) |-> !take_irq);                   // R2
    AST_THR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_req && (thr_q != '0) && (req_prio >= thr_q)) |-> !take_irq); // R5
    AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !nmi_req) |-> !take_irq);                // R8

endmodule

// File: tb/irq_prio_gate_test.sv
module irq_prio_gate_test;

    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, nmi_req = 1'b0;
    logic [PW-1:0] req_prio = '0, thr_wdata = '0;
    logic          thr_wr = 1'b0, thr_wr_max = 1'b0;
    logic          gmask_set = 1'b0, gmask_clr = 1'b0;
    logic          take_irq, gmask_q;
    logic [PW-1:0] thr_q;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    irq_prio_gate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
        .nmi_req(nmi_req), .thr_wr(thr_wr), .thr_wr_max(thr_wr_max),
        .thr_wdata(thr_wdata), .gmask_set(gmask_set), .gmask_clr(gmask_clr),
        .take_irq(take_irq), .gmask_q(gmask_q), .thr_q(thr_q)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_take(int v, int p, int n, int g, int t);
        return (n != 0 || (v != 0 && g == 0 && (t == 0 || p < t))) ? 1 : 0;
    endfunction

    task automatic load_direct(input int v);
        @(negedge clk); thr_wr = 1'b1; thr_wdata = PW'(v);
        @(negedge clk); thr_wr = 1'b0;
    endtask

    task automatic load_max(input int v);
        @(negedge clk); thr_wr_max = 1'b1; thr_wdata = PW'(v);
        @(negedge clk); thr_wr_max = 1'b0;
    endtask

    task automatic strobe(input logic s, input logic c);
        @(negedge clk); gmask_set = s; gmask_clr = c;
        @(negedge clk); gmask_set = 1'b0; gmask_clr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 gmask after reset", gmask_q, 0);
        check("R1 thr after reset", thr_q, 0);
        req_valid = 1'b0; nmi_req = 1'b0; #1;
        check("R8 idle no take", take_irq, 0);
    endtask

    task automatic t_grid;
        for (int t = 0; t < 8; t++) begin
            load_direct(t);
            check("R6 direct load", thr_q, t);
            for (int p = 0; p < 8; p++) begin
                req_valid = 1'b1; req_prio = PW'(p); #1;
                check("R5 threshold grid", take_irq, model_take(1, p, 0, 0, t));
            end
        end
        req_valid = 1'b0; #1;
        check("R8 no valid no take", take_irq, 0);
    endtask

    task automatic t_global;
        load_direct(0);
        strobe(1'b1, 1'b0);
        check("R3 set blocks", gmask_q, 1);
        req_valid = 1'b1; req_prio = 3'd0; #1;
        check("R2 blocked prio0", take_irq, 0);
        nmi_req = 1'b1; #1;
        check("R4 nmi while blocked", take_irq, 1);
        nmi_req = 1'b0;
        strobe(1'b1, 1'b1);
        check("R3 set wins over clear", gmask_q, 1);
        strobe(1'b0, 1'b1);
        check("R3 clear opens", gmask_q, 0);
        #1; check("R2 open passes", take_irq, 1);
        req_valid = 1'b0;
    endtask

    task automatic t_nmi;
        load_direct(1);
        req_valid = 1'b0; nmi_req = 1'b1; #1;
        check("R4 nmi without valid under thr", take_irq, 1);
        req_valid = 1'b1; req_prio = 3'd7; #1;
        check("R4 nmi with masked req", take_irq, 1);
        nmi_req = 1'b0; #1;
        check("R5 prio7 masked thr1", take_irq, 0);
        req_valid = 1'b0;
    endtask

    task automatic t_tighten;
        load_direct(0);
        load_max(5); check("R7 accept from off", thr_q, 5);
        load_max(6); check("R7 reject looser", thr_q, 5);
        load_max(5); check("R7 reject equal", thr_q, 5);
        load_max(0); check("R7 reject zero", thr_q, 5);
        load_max(2); check("R7 accept tighter", thr_q, 2);
        load_direct(6); check("R6 direct loosens", thr_q, 6);
        @(negedge clk); thr_wr = 1'b1; thr_wr_max = 1'b1; thr_wdata = 3'd7;
        @(negedge clk); thr_wr = 1'b0; thr_wr_max = 1'b0;
        check("R6 direct beats tighten", thr_q, 7);
        load_direct(0); check("R6 restore zero", thr_q, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_grid();
        t_global();
        t_nmi();
        t_tighten();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++; n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule